// File: doc/BRIEF.md
# Card Clock Divider with Edge Select

This block derives the clock sent to a memory card from the kernel clock. A 10-bit divide value N sets the rate. When N is nonzero the card clock runs at the kernel rate divided by 2×N, with a high phase and a low phase of N kernel cycles each. When N is zero the divider is bypassed: the kernel clock passes through a glitch-free gate, and output bits are always launched on its falling edge. A one-kernel-cycle launch strobe tells the command and data shift logic when to present the next bit. In divide mode an edge-select input chooses whether that strobe marks the rising or the falling card-clock edge.

The card clock is held low when the power sequencer is not in the on state. It is also held low when the stop-clock input is raised, and when power-save is enabled and no transfer is active. A stop is taken only at a low phase, so a high phase that has started always completes. A new divide value is picked up only when the card clock falls, or while the clock is stopped, so no shortened pulse can appear. The bus-width selection is decoded here into a lane count for the data path.

Top module: `cardclk_gen`

## Requirements
- R1: While reset is held, card_clk and launch_stb are 0 and bus_lanes is 1.
- R2: With a divide value N from 1 to 1023 and the clock running, card_clk is high for N kernel cycles and low for N kernel cycles, repeating.
- R3: With divide value 0 and the clock running, card_clk equals the kernel clock, and launch_stb is 1 in every kernel cycle whatever edge_fall is.
- R4: With N nonzero and edge_fall=0, launch_stb is 1 in the kernel cycle that starts at the edge where card_clk rises.
- R5: With N nonzero and edge_fall=1, launch_stb is 1 in the kernel cycle that starts at the edge where card_clk falls.
- R6: In divide mode, launch_stb pulses exactly once per card-clock period, for one kernel cycle.
- R7: bus_sel is decoded one kernel cycle later into bus_lanes: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8, and 2'b11 also gives 8 (the upper bit wins).
- R8: While pwr_on is 0, card_clk stays low and launch_stb stays 0, once any high phase already in progress has ended. Raising pwr_on again resumes the normal period.
- R9: With pwr_save=1, the clock runs normally while xfer_active=1 and is held low with no launches while xfer_active=0.
- R10: While clk_stop is 1, card_clk is held low and launch_stb is 0.
- R11: A new divide value written during a high phase does not shorten or stretch that high phase. The following low phase and all later phases use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | 10 | Divide value N; 0 selects bypass |
| edge_fall | input | 1 | Launch-edge select in divide mode: 0 rising, 1 falling |
| bus_sel | input | 2 | Bus-width select: bit 0 for 4 lanes, bit 1 for 8 lanes |
| pwr_save | input | 1 | Power-save enable: stop the clock while idle |
| pwr_on | input | 1 | Power sequencer is in the on state |
| xfer_active | input | 1 | A command or data transfer is in progress |
| clk_stop | input | 1 | Flow-control request to freeze the card clock |
| card_clk | output | 1 | Clock to the card |
| launch_stb | output | 1 | One-cycle strobe for launching output bits |
| bus_lanes | output | 4 | Number of active data lanes: 1, 4 or 8 |

## Verification
In divide mode, card_clk and launch_stb change at the same kernel edge that ends a count. The bench therefore samples both 5 ns after each rising kernel edge and measures phase lengths by counting samples between transitions. After a configuration change it waits out the old period and then one full new period before it measures. In bypass the gate register updates on the falling kernel edge, so card_clk is checked twice per cycle: high 5 ns after the rising edge and low 15 ns after it. bus_lanes is registered once, so it is checked at the first sample after bus_sel changes. The hold conditions are checked after a wait longer than one old period, because a high phase in progress must first end.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

    localparam int DIV_W_DEFAULT = 10;
    localparam int LANE_W        = 4;

    typedef enum logic [1:0] {
        BW_ONE   = 2'b00,
        BW_FOUR  = 2'b01,
        BW_EIGHT = 2'b10,
        BW_BOTH  = 2'b11
    } bus_sel_e;

    typedef struct packed {
        logic run;
        logic launch_fall;
    } clk_ctrl_t;

    function automatic logic [LANE_W-1:0] lanes_of(input logic [1:0] sel);
        logic [LANE_W-1:0] n;
        case (bus_sel_e'(sel))
            BW_FOUR:  n = LANE_W'(4);
            BW_EIGHT: n = LANE_W'(8);
            BW_BOTH:  n = LANE_W'(8);
            default:  n = LANE_W'(1);
        endcase
        return n;
    endfunction

    function automatic logic run_allowed(input logic pwr_on, input logic stop,
                                         input logic save, input logic busy);
        return pwr_on && !stop && (!save || busy);
    endfunction

endpackage

// File: rtl/cardclk_cfg.sv
module cardclk_cfg
    import cardclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_sel,
    input  logic              edge_fall,
    input  logic              pwr_save,
    input  logic              pwr_on,
    input  logic              xfer_active,
    input  logic              clk_stop,
    output clk_ctrl_t         ctrl,
    output logic [LANE_W-1:0] bus_lanes
);

    logic [LANE_W-1:0] lanes_q;

    always_ff @(posedge clk) begin
        if (rst) lanes_q <= LANE_W'(1);
        else     lanes_q <= lanes_of(bus_sel);
    end

    always_comb begin
        ctrl.run         = run_allowed(pwr_on, clk_stop, pwr_save, xfer_active);
        ctrl.launch_fall = edge_fall;
    end

    assign bus_lanes = lanes_q;

    // R7: exactly one lane count is legal
    p_lanes_legal_r7: assert property (@(posedge clk) disable iff (rst)
        (lanes_q == 4'd1) || (lanes_q == 4'd4) || (lanes_q == 4'd8));

endmodule

// File: rtl/cardclk_div.sv
module cardclk_div
    import cardclk_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    input  clk_ctrl_t        ctrl,
    output logic             div_clk,
    output logic             bypass,
    output logic             launch
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] n_act_q;
    logic             edge_act_q;
    logic             div_q;
    logic             stb_q;
    logic             terminal;
    logic             in_bypass;

    assign in_bypass = (n_act_q == '0);
    assign terminal  = (cnt_q == n_act_q - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            n_act_q    <= '0;
            edge_act_q <= 1'b0;
            div_q      <= 1'b0;
            stb_q      <= 1'b0;
        end else if (in_bypass) begin
            cnt_q      <= '0;
            div_q      <= 1'b0;
            n_act_q    <= div_val;
            edge_act_q <= ctrl.launch_fall;
            stb_q      <= ctrl.run;
        end else if (!div_q && !ctrl.run) begin
            cnt_q      <= '0;
            n_act_q    <= div_val;
            edge_act_q <= ctrl.launch_fall;
            stb_q      <= 1'b0;
        end else if (terminal) begin
            cnt_q <= '0;
            div_q <= !div_q;
            if (div_q) begin
                stb_q      <= edge_act_q;
                n_act_q    <= div_val;
                edge_act_q <= ctrl.launch_fall;
            end else begin
                stb_q <= !edge_act_q;
            end
        end else begin
            cnt_q <= cnt_q + ONE;
            stb_q <= 1'b0;
        end
    end

    assign div_clk = div_q;
    assign bypass  = in_bypass;
    assign launch  = stb_q;

    // R2: counter never passes the active terminal value
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        !in_bypass |-> (cnt_q < n_act_q));

    // R3: the divided path stays quiet in bypass
    p_bypass_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        in_bypass |-> !div_q);

    // R4: a rising divided edge carries a strobe when launching on rise
    p_rise_launch_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(div_q) |-> (stb_q == !edge_act_q));

    // R5: a falling divided edge carries a strobe when launching on fall
    p_fall_launch_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(div_q) |-> (stb_q == $past(edge_act_q)));

    // R8: a stopped low clock stays low while running is disallowed
    p_hold_low_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !div_q && !in_bypass) |=> !div_q);

    // R11: the active divide value only changes while the clock is low
    p_load_low_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(n_act_q) |-> !div_q);

endmodule

// File: rtl/cardclk_gate.sv
module cardclk_gate (
    input  logic clk,
    input  logic rst,
    input  logic pass_en,
    input  logic div_clk,
    output logic card_clk
);

    logic gate_q;

    // Enable changes only while the kernel clock is low: no glitch on the AND.
    always_ff @(negedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= pass_en;
    end

    assign card_clk = (clk & gate_q) | div_clk;

    // R3: pass-through and divided paths are never active together
    p_one_path_r3: assert property (@(posedge clk) disable iff (rst)
        div_clk |-> !pass_en);

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
    import cardclk_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              edge_fall,
    input  logic [1:0]        bus_sel,
    input  logic              pwr_save,
    input  logic              pwr_on,
    input  logic              xfer_active,
    input  logic              clk_stop,
    output logic              card_clk,
    output logic              launch_stb,
    output logic [LANE_W-1:0] bus_lanes
);

    clk_ctrl_t ctrl;
    logic      div_clk;
    logic      bypass;

    cardclk_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .edge_fall   (edge_fall),
        .pwr_save    (pwr_save),
        .pwr_on      (pwr_on),
        .xfer_active (xfer_active),
        .clk_stop    (clk_stop),
        .ctrl        (ctrl),
        .bus_lanes   (bus_lanes)
    );

    cardclk_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .div_val (div_val),
        .ctrl    (ctrl),
        .div_clk (div_clk),
        .bypass  (bypass),
        .launch  (launch_stb)
    );

    cardclk_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .pass_en  (bypass && ctrl.run),
        .div_clk  (div_clk),
        .card_clk (card_clk)
    );

    // R6: in divide mode a strobe is never followed by another while rising-only
    p_single_stb_r6: assert property (@(posedge clk) disable iff (rst)
        (launch_stb && div_clk && !bypass && !edge_fall && $stable(edge_fall)) |=> !launch_stb);

endmodule

// File: tb/cardclk_gen_test.sv
module cardclk_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] div_val = '0;
    logic       edge_fall = 1'b0;
    logic [1:0] bus_sel = 2'b00;
    logic       pwr_save = 1'b0;
    logic       pwr_on = 1'b0;
    logic       xfer_active = 1'b0;
    logic       clk_stop = 1'b0;
    logic       card_clk;
    logic       launch_stb;
    logic [3:0] bus_lanes;

    int  errs = 0;
    int  checks = 0;
    int  prev_n = 0;
    bit  done = 0;
    logic c, s;

    always #10 clk = ~clk;

    cardclk_gen uut (
        .clk(clk), .rst(rst), .div_val(div_val), .edge_fall(edge_fall),
        .bus_sel(bus_sel), .pwr_save(pwr_save), .pwr_on(pwr_on),
        .xfer_active(xfer_active), .clk_stop(clk_stop),
        .card_clk(card_clk), .launch_stb(launch_stb), .bus_lanes(bus_lanes)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
        c = card_clk;
        s = launch_stb;
    endtask

    task automatic wait_rise();
        logic p;
        p = c;
        for (int i = 0; i < 5000; i++) begin
            step();
            if (!p && c) return;
            p = c;
        end
        chk(0, "R2 no rising edge", 0, 1);
    endtask

    // Measure one full period starting at a rising edge
    task automatic period(input int n, input bit e, input string tag);
        int hi, lo, nst, guard;
        logic rise_s, fall_s;
        wait_rise();
        rise_s = s;
        hi = 0; lo = 0; nst = 0; guard = 0;
        do begin hi++; nst += int'(s); step(); guard++; end while (c && guard < 3000);
        fall_s = s;
        do begin lo++; nst += int'(s); step(); guard++; end while (!c && guard < 6000);
        chk(hi == n, {tag, " R2 high length"}, hi, n);
        chk(lo == n, {tag, " R2 low length"}, lo, n);
        chk(nst == 1, {tag, " R6 strobes per period"}, nst, 1);
        if (!e) chk(rise_s == 1'b1, {tag, " R4 strobe at rise"}, int'(rise_s), 1);
        else    chk(fall_s == 1'b1, {tag, " R5 strobe at fall"}, int'(fall_s), 1);
    endtask

    task automatic measure(input int n, input bit e, input string tag);
        div_val = 10'(n);
        edge_fall = e;
        repeat (2*prev_n + 2*n + 6) step();
        prev_n = n;
        period(n, e, tag);
    endtask

    task automatic check_held(input string tag, input int settle);
        int bad;
        repeat (settle) step();
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (c || s) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic check_bypass(input bit e, input bit expect_run, input string tag);
        int bad;
        div_val = '0;
        edge_fall = e;
        repeat (2*prev_n + 6) step();
        prev_n = 0;
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            step();
            if (c !== expect_run || s !== expect_run) bad++;
            #10;
            if (card_clk !== 1'b0) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int hi, lo, hi2, guard;
        // R1 reset state
        repeat (3) step();
        chk(c == 1'b0, "R1 card_clk in reset", int'(c), 0);
        chk(s == 1'b0, "R1 launch_stb in reset", int'(s), 0);
        chk(bus_lanes == 4'd1, "R1 lanes in reset", int'(bus_lanes), 1);
        rst = 1'b0;
        pwr_on = 1'b1;

        // R3 bypass, both edge settings
        check_bypass(1'b0, 1'b1, "R3 bypass edge0");
        check_bypass(1'b1, 1'b1, "R3 bypass edge1");

        // R2 R4 R5 R6 sweep of divide values
        for (int n = 1; n <= 24; n++) begin
            measure(n, 1'b0, "sweep e0");
            measure(n, 1'b1, "sweep e1");
        end
        measure(100, 1'b0, "n100");
        measure(512, 1'b1, "n512");
        measure(1023, 1'b0, "n1023");
        measure(1023, 1'b1, "n1023");

        // R11 change during a high phase
        measure(5, 1'b0, "pre R11");
        wait_rise();
        div_val = 10'd9;
        hi = 0; lo = 0; hi2 = 0; guard = 0;
        do begin hi++; step(); guard++; end while (c && guard < 100);
        do begin lo++; step(); guard++; end while (!c && guard < 100);
        do begin hi2++; step(); guard++; end while (c && guard < 100);
        chk(hi == 5, "R11 high kept old length", hi, 5);
        chk(lo == 9, "R11 low uses new value", lo, 9);
        chk(hi2 == 9, "R11 next high uses new value", hi2, 9);
        prev_n = 9;

        // R8 power off / on
        pwr_on = 1'b0;
        check_held("R8 held low while off", 2*prev_n + 4);
        pwr_on = 1'b1;
        period(9, 1'b0, "R8 resume");

        // R9 power save
        pwr_save = 1'b1;
        xfer_active = 1'b1;
        period(9, 1'b0, "R9 save busy");
        xfer_active = 1'b0;
        check_held("R9 held low when idle", 2*prev_n + 4);
        xfer_active = 1'b1;
        period(9, 1'b0, "R9 resume");
        pwr_save = 1'b0;

        // R10 stop clock
        clk_stop = 1'b1;
        check_held("R10 held low on stop", 2*prev_n + 4);
        clk_stop = 1'b0;
        period(9, 1'b0, "R10 resume");

        // R8 bypass while off
        pwr_on = 1'b0;
        check_bypass(1'b0, 1'b0, "R8 bypass off");
        pwr_on = 1'b1;

        // R7 bus width decode
        for (int k = 0; k < 4; k++) begin
            int exp_l;
            bus_sel = 2'(k);
            step();
            exp_l = (k == 0) ? 1 : (k == 1) ? 4 : 8;
            chk(int'(bus_lanes) == exp_l, "R7 lanes decode", int'(bus_lanes), exp_l);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule